// File: doc/BRIEF.md
# DRAM Refresh Sequencer

Every DRAM row loses its charge over time, whether or not it is accessed, so each row has to be rewritten periodically. This block produces that refresh work. It raises a refresh request towards the command scheduler. It waits for a grant, and for each accepted grant it advances a row pointer that wraps after the last row. An interval timer sets the pace of the refresh work.

The mode input selects among three behaviours. In distributed mode, each interval tick asks for a single row, so normal traffic is only ever held off for one command. In burst mode, each tick starts a full sweep over all rows back to back, and the ready output stays low until the sweep ends. In self-refresh mode, the device refreshes itself: the block stops requesting and reports that the controller side is idle. Leaving self-refresh holds ready low for a fixed recovery time before traffic may resume.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, ref_req_o=0, ready_o=1, sr_active_o=0 and ref_row_o=0.
- R2: With mode_i=2'b00 (distributed; 2'b11 behaves the same), a request is raised every INTERVAL cycles of normal operation. The first request is visible INTERVAL cycles after reset is released, and ready_o stays 1 while it waits.
- R3: A raised request stays high until a cycle with ref_gnt_i=1. Ticks that arrive while it waits do not add to it, so exactly one row is refreshed, and ref_req_o falls in the cycle after a distributed grant.
- R4: ref_row_o advances by one only on a clock edge where ref_req_o and ref_gnt_i are both 1. It wraps from NUM_ROWS-1 to 0. A grant while no request is raised changes nothing.
- R5: With mode_i=2'b01 (burst), a tick starts a sweep that keeps ref_req_o high until NUM_ROWS grants have been taken. During the sweep ready_o is 0. In the cycle after the last grant, ready_o is 1 and ref_req_o is 0, and the row pointer is back where the sweep started.
- R6: With mode_i=2'b10 and no request pending, the block enters self-refresh on the next edge. sr_active_o becomes 1, ref_req_o and ready_o are 0, and ref_row_o is frozen for as long as the mode is held.
- R7: When mode_i leaves 2'b10, sr_active_o falls on the next edge. ready_o then stays 0 for exactly SR_EXIT cycles before it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00/11 distributed, 01 burst, 10 self-refresh |
| ref_gnt_i | input | 1 | Scheduler accepts the refresh request |
| ref_req_o | output | 1 | Refresh request for row ref_row_o |
| ref_row_o | output | ROW_W | Row to refresh next |
| ready_o | output | 1 | Normal accesses permitted |
| sr_active_o | output | 1 | Device is in self-refresh |

## Verification
A corrupted row pointer appears on ref_row_o at once, and at the latest it shows after the next granted refresh, when the step is not exactly one. A burst sweep also returns the pointer to where it started, so a miscounted remaining-rows register shows up as a wrong final row or as ready_o returning early or late. A faulty state register breaks the pairing of ready_o, sr_active_o and ref_req_o within one cycle. A faulty exit timer shifts the rise of ready_o away from exactly SR_EXIT cycles after self-refresh ends.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_BURST, ST_SELF, ST_EXIT} ref_state_e;
  localparam logic [1:0] MODE_BURST = 2'b01;
  localparam logic [1:0] MODE_SELF  = 2'b10;
endpackage

// File: rtl/ref_cycle_timer.sv
module ref_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/ref_row_counter.sv
module ref_row_counter #(
  parameter int NUM_ROWS = 16,
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(NUM_ROWS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   row_o <= '0;
    else if (inc_i) row_o <= (row_o == LAST) ? '0 : row_o + 1'b1;
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int INTERVAL = 20,
  parameter int SR_EXIT  = 6,
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ref_gnt_i,
  output logic             ref_req_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             ready_o,
  output logic             sr_active_o
);
  localparam int LW = $clog2(NUM_ROWS + 1);

  ref_state_e    state_q, state_d;
  logic          pend_q;
  logic [LW-1:0] left_q;
  logic          tick, exit_done, dist_mode;

  assign dist_mode = (mode_i != MODE_BURST) && (mode_i != MODE_SELF);

  ref_cycle_timer #(.LIMIT(INTERVAL)) u_ival (
    .clk_i, .rst_ni, .en_i(state_q == ST_RUN), .done_o(tick)
  );

  ref_cycle_timer #(.LIMIT(SR_EXIT)) u_exit (
    .clk_i, .rst_ni, .en_i(state_q == ST_EXIT), .done_o(exit_done)
  );

  ref_row_counter #(.NUM_ROWS(NUM_ROWS)) u_row (
    .clk_i, .rst_ni, .inc_i(ref_req_o && ref_gnt_i), .row_o(ref_row_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (mode_i == MODE_SELF && !pend_q)      state_d = ST_SELF;
        else if (tick && mode_i == MODE_BURST)  state_d = ST_BURST;
      end
      ST_BURST: if (ref_gnt_i && left_q == LW'(1)) state_d = ST_RUN;
      ST_SELF:  if (mode_i != MODE_SELF)           state_d = ST_EXIT;
      ST_EXIT:  if (exit_done)                     state_d = ST_RUN;
      default:                                     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      // single pending slot: extra ticks while waiting are absorbed
      if (state_q == ST_RUN) begin
        if (tick && dist_mode) pend_q <= 1'b1;
        else if (ref_gnt_i)    pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b0;
      end
      if (state_q == ST_RUN && state_d == ST_BURST) left_q <= LW'(NUM_ROWS);
      else if (state_q == ST_BURST && ref_gnt_i)    left_q <= left_q - 1'b1;
    end
  end

  assign ref_req_o   = (state_q == ST_BURST) || (state_q == ST_RUN && pend_q);
  assign ready_o     = (state_q == ST_RUN);
  assign sr_active_o = (state_q == ST_SELF);
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int NUM_ROWS = 16,
  parameter int ROW_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_gnt_i,
  input logic             ref_req_o,
  input logic [ROW_W-1:0] ref_row_o,
  input logic             ready_o,
  input logic             sr_active_o
);
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_gnt_i) |=> ref_req_o);

  p_row_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_req_o && ref_gnt_i) |=> $stable(ref_row_o));

  p_row_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_gnt_i && ref_row_o == ROW_W'(NUM_ROWS - 1)) |=> ref_row_o == '0);

  p_sr_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_active_o |-> (!ref_req_o && !ready_o));

  p_exit_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sr_active_o) |-> !ready_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_chk (
  .clk_i, .rst_ni, .ref_gnt_i, .ref_req_o, .ref_row_o, .ready_o, .sr_active_o
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int NUM_ROWS = 16;
  localparam int INTERVAL = 20;
  localparam int SR_EXIT  = 6;
  localparam int ROW_W    = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic ref_gnt_i = 1'b0;
  logic ref_req_o, ready_o, sr_active_o;
  logic [ROW_W-1:0] ref_row_o;

  int checks = 0;
  int errors = 0;
  int exp_row = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_refresh_seq #(.NUM_ROWS(NUM_ROWS), .INTERVAL(INTERVAL), .SR_EXIT(SR_EXIT)) u_dut (
    .clk_i(clk), .rst_ni, .mode_i, .ref_gnt_i,
    .ref_req_o, .ref_row_o, .ready_o, .sr_active_o
  );

  // {mode, number of handshakes}
  localparam logic [9:0] VEC [5] = '{
    {2'b00, 8'd3}, {2'b00, 8'd14}, {2'b01, 8'd16}, {2'b11, 8'd2}, {2'b01, 8'd16}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_req();
    for (int i = 0; i < 200 && !ref_req_o; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req", ref_req_o, 0);
    chk("R1 ready", ready_o, 1);
    chk("R1 sr", sr_active_o, 0);
    chk("R1 row", ref_row_o, 0);
    rst_ni = 1'b1;

    // R2 first request exactly INTERVAL cycles after release
    begin
      int first = -1;
      for (int n = 1; n <= INTERVAL + 2; n++) begin
        @(negedge clk);
        if (ref_req_o && first < 0) first = n;
      end
      chk("R2 first request cycle", first, INTERVAL);
      chk("R2 ready while waiting", ready_o, 1);
    end

    // R3 request held across a tick, one row per grant
    repeat (30) @(negedge clk);
    chk("R3 req held", ref_req_o, 1);
    chk("R3 row unchanged while waiting", ref_row_o, exp_row);
    ref_gnt_i = 1'b1;
    @(negedge clk);
    ref_gnt_i = 1'b0;
    exp_row = (exp_row + 1) % NUM_ROWS;
    chk("R3 single row", ref_row_o, exp_row);
    chk("R3 req drops", ref_req_o, 0);

    // R4 grant without request has no effect
    ref_gnt_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 stray grant", ref_row_o, exp_row);
    ref_gnt_i = 1'b0;

    // vector table: distributed and burst sweeps
    foreach (VEC[v]) begin
      logic [1:0] m;
      int n;
      m = VEC[v][9:8];
      n = int'(VEC[v][7:0]);
      mode_i = m;
      for (int g = 0; g < n; g++) begin
        wait_req();
        chk("R2 R5 request present", ref_req_o, 1);
        chk(m == 2'b01 ? "R5 ready low in sweep" : "R2 ready high", ready_o, m == 2'b01 ? 0 : 1);
        ref_gnt_i = 1'b1;
        @(negedge clk);
        ref_gnt_i = 1'b0;
        exp_row = (exp_row + 1) % NUM_ROWS;
        chk("R4 row step", ref_row_o, exp_row);
        if (m != 2'b01) chk("R3 req drops after grant", ref_req_o, 0);
      end
      if (m == 2'b01) begin
        chk("R5 req off after sweep", ref_req_o, 0);
        chk("R5 ready after sweep", ready_o, 1);
      end
      mode_i = 2'b00;
    end

    // R6 self-refresh entry
    mode_i = 2'b10;
    @(negedge clk);
    chk("R6 sr active", sr_active_o, 1);
    chk("R6 ready low", ready_o, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 3 * INTERVAL; i++) begin
        @(negedge clk);
        if (ref_req_o) seen++;
      end
      chk("R6 no request", seen, 0);
    end
    chk("R6 row frozen", ref_row_o, exp_row);

    // R7 exit delay
    mode_i = 2'b00;
    begin
      int low = 0;
      @(negedge clk);
      chk("R7 sr drops", sr_active_o, 0);
      while (!ready_o && low < 50) begin
        low++;
        @(negedge clk);
      end
      chk("R7 exit delay cycles", low, SR_EXIT);
    end

    // distributed refresh resumes after exit
    wait_req();
    ref_gnt_i = 1'b1;
    @(negedge clk);
    ref_gnt_i = 1'b0;
    exp_row = (exp_row + 1) % NUM_ROWS;
    chk("R4 row after exit", ref_row_o, exp_row);

    done = 1;
    finish_run();
  end
endmodule